// File: doc/BRIEF.md
# Insertion History Log Writer

This block keeps a rolling record of the last sixteen times a module was seated in a slot. The records live in a small byte-addressed store that stands in for the mailbox area of the module's identity memory. A single byte at address 0 holds the index of the newest record. Record k occupies 26 consecutive bytes starting at address 1 + 26·k.

The block watches an asynchronous presence input, which it passes through a two-flop synchronizer. A rising edge of that input, seen while the compatible-class qualifier is high, starts a log write. The block first steps the newest-entry index forward, with wraparound, and latches the record fields. It then writes the record into the store one byte per clock while `busy_o` is high.

The chassis identifier, slot number, date-time stamp and chassis-type byte come in as parallel inputs. The writer forces the low nibble of the chassis-type byte and the whole sub-code byte to zero. A registered read port lets the log, the index byte included, be examined at any time.

Top module: `ilog_writer`

## Requirements
- R1: After reset, `busy_o` is low and the index byte at address 0 reads 0x0F. The first record written after reset therefore lands in entry 0.
- R2: A write starts only when the synchronized presence input rises while `compat_i` is high. `busy_o` goes high after the third rising clock edge that follows `present_i` going high. A rise while `compat_i` is low starts nothing, and neither does a fall of `present_i`.
- R3: Each accepted trigger sets the index to (index + 1) mod 16, so entry 15 is followed by entry 0. The new index is readable at address 0 once `busy_o` is high. A wrapped write replaces only entry 0 and leaves the other entries intact.
- R4: Record k sits at addresses 1+26k to 26+26k, in this byte order:
  - bytes 0–15: identifier byte i = `uuid_i[8i+7:8i]`;
  - byte 16: `slot_i`;
  - bytes 17–23: stamp byte j = `stamp_i[8j+7:8j]` (year first, second last);
  - byte 24: `ctype_i` with bits 3:0 forced to 0000b;
  - byte 25: always 0x00.
- R5: `busy_o` stays high for exactly 26 consecutive cycles per record, and the block writes one record byte per cycle. No byte is written while `busy_o` is low.
- R6: A trigger that arrives while `busy_o` is high is ignored. The index does not move again and the record is not restarted.
- R7: Record fields are captured in the cycle the trigger is accepted. Input changes during `busy_o` do not alter the stored record.
- R8: `rd_data_o` returns the byte at `rd_addr_i` one clock after the address is applied. Addresses beyond the last log byte (416) read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| present_i | input | 1 | Asynchronous slot presence level |
| compat_i | input | 1 | High when the seated module is of the compatible class |
| uuid_i | input | 128 | Chassis identifier, byte 0 in bits 7:0 |
| slot_i | input | 8 | Slot number byte |
| stamp_i | input | 56 | Date-time stamp, year in bits 7:0, second in bits 55:48 |
| ctype_i | input | 8 | Chassis-type byte (low nibble replaced by zero) |
| busy_o | output | 1 | High while a record is being written |
| rd_addr_i | input | 9 | Read byte address (0 = newest-entry index) |
| rd_data_o | output | 8 | Registered read data |

## Verification
If the index register holds the wrong value, the next read of address 0 shows it, and every byte of the following record appears under the wrong entry. A byte-counter fault shows up at once as a `busy_o` window that is not 26 cycles long, or as bytes shifted into a neighbouring field. Faulty field capture appears only when the record is read back. For that reason each write is followed by a full read-out of its 26 bytes, and after the wrap the whole log is read again to confirm that older entries survived.

// File: rtl/ilog_pkg.sv
package ilog_pkg;
  localparam int BYTE_W   = 8;
  localparam int PTR_ADDR = 0;
  localparam int LOG_BASE = 1;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ilog_edge_detect.sv
module ilog_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [SYNC_STAGES:0] chain_q;
  logic [SYNC_STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[SYNC_STAGES-1:0], async_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  // last synchronized stage high, delayed copy still low
  assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/ilog_rec_mux.sv
module ilog_rec_mux
  import ilog_pkg::*;
#(
  parameter int UUID_BYTES  = 16,
  parameter int STAMP_BYTES = 7,
  localparam int REC_BYTES  = UUID_BYTES + STAMP_BYTES + 3,
  localparam int IDX_W      = $clog2(REC_BYTES)
) (
  input  logic [UUID_BYTES*BYTE_W-1:0]  uuid_i,
  input  byte_t                         slot_i,
  input  logic [STAMP_BYTES*BYTE_W-1:0] stamp_i,
  input  byte_t                         ctype_i,
  input  logic [IDX_W-1:0]              idx_i,
  output byte_t                         byte_o
);
  byte_t rec [REC_BYTES];

  for (genvar i = 0; i < UUID_BYTES; i++) begin : g_uuid
    assign rec[i] = uuid_i[BYTE_W*i +: BYTE_W];
  end

  assign rec[UUID_BYTES] = slot_i;

  for (genvar j = 0; j < STAMP_BYTES; j++) begin : g_stamp
    assign rec[UUID_BYTES+1+j] = stamp_i[BYTE_W*j +: BYTE_W];
  end

  // information nibble forced to zero, sub code constant zero
  assign rec[REC_BYTES-2] = ctype_i & 8'hF0;
  assign rec[REC_BYTES-1] = 8'h00;

  assign byte_o = (idx_i < IDX_W'(REC_BYTES)) ? rec[idx_i] : 8'h00;
endmodule

// File: rtl/ilog_store.sv
module ilog_store
  import ilog_pkg::*;
#(
  parameter int DEPTH   = 417,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  byte_t             wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output byte_t             rdata_o
);
  byte_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = (raddr_i < ADDR_W'(DEPTH)) ? mem_q[raddr_i] : 8'h00;
endmodule

// File: rtl/ilog_writer.sv
module ilog_writer
  import ilog_pkg::*;
#(
  parameter int N_ENTRIES   = 16,
  parameter int UUID_BYTES  = 16,
  parameter int STAMP_BYTES = 7,
  parameter int SYNC_STAGES = 2,
  localparam int REC_BYTES  = UUID_BYTES + STAMP_BYTES + 3,
  localparam int DEPTH      = LOG_BASE + N_ENTRIES * REC_BYTES,
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          present_i,
  input  logic                          compat_i,
  input  logic [UUID_BYTES*BYTE_W-1:0]  uuid_i,
  input  logic [BYTE_W-1:0]             slot_i,
  input  logic [STAMP_BYTES*BYTE_W-1:0] stamp_i,
  input  logic [BYTE_W-1:0]             ctype_i,
  output logic                          busy_o,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  output logic [BYTE_W-1:0]             rd_data_o
);
  localparam int PTR_W = $clog2(N_ENTRIES);
  localparam int IDX_W = $clog2(REC_BYTES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  // trigger qualification
  logic rise;
  ilog_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .async_i(present_i),
    .rise_o (rise)
  );

  // control state
  logic             busy_q, busy_d;
  logic [IDX_W-1:0] cnt_q,  cnt_d;
  logic [PTR_W-1:0] ptr_q,  ptr_d;
  logic             start;
  logic             cap_en;

  always_comb begin
    start  = rise & compat_i & ~busy_q;
    cap_en = start;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    ptr_d  = ptr_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      ptr_d  = (ptr_q == PTR_W'(N_ENTRIES-1)) ? '0 : ptr_q + 1'b1;
    end else if (busy_q) begin
      if (cnt_q == IDX_W'(REC_BYTES-1)) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ptr_q  <= PTR_W'(N_ENTRIES-1);
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      ptr_q  <= ptr_d;
    end
  end

  // field capture (datapath, no reset)
  logic [UUID_BYTES*BYTE_W-1:0]  cap_uuid_q;
  byte_t                         cap_slot_q;
  logic [STAMP_BYTES*BYTE_W-1:0] cap_stamp_q;
  byte_t                         cap_ctype_q;

  always_ff @(posedge clk_i) begin
    if (cap_en) begin
      cap_uuid_q  <= uuid_i;
      cap_slot_q  <= slot_i;
      cap_stamp_q <= stamp_i;
      cap_ctype_q <= ctype_i;
    end
  end

  // record byte selection
  byte_t mem_wdata;
  ilog_rec_mux #(.UUID_BYTES(UUID_BYTES), .STAMP_BYTES(STAMP_BYTES)) u_mux (
    .uuid_i (cap_uuid_q),
    .slot_i (cap_slot_q),
    .stamp_i(cap_stamp_q),
    .ctype_i(cap_ctype_q),
    .idx_i  (cnt_q),
    .byte_o (mem_wdata)
  );

  // store
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  byte_t             mem_rdata;

  assign mem_we    = busy_q;
  assign mem_waddr = ADDR_W'(LOG_BASE) + ADDR_W'(ptr_q) * ADDR_W'(REC_BYTES) + ADDR_W'(cnt_q);

  ilog_store #(.DEPTH(DEPTH)) u_store (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .waddr_i(mem_waddr),
    .wdata_i(mem_wdata),
    .raddr_i(rd_addr_i),
    .rdata_o(mem_rdata)
  );

  // registered read port
  byte_t rd_data_q, rd_data_d;

  always_comb begin
    rd_data_d = (rd_addr_i == ADDR_W'(PTR_ADDR)) ? byte_t'(ptr_q) : mem_rdata;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
    end else begin
      rd_data_q <= rd_data_d;
    end
  end

  assign rd_data_o = rd_data_q;
  assign busy_o    = busy_q;
endmodule

// File: rtl/ilog_writer_chk.sv
module ilog_writer_chk #(
  parameter int N_ENTRIES = 16,
  parameter int REC_BYTES = 26,
  localparam int PTR_W    = $clog2(N_ENTRIES),
  localparam int IDX_W    = $clog2(REC_BYTES)
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             busy_i,
  input logic [PTR_W-1:0] ptr_i,
  input logic             we_i,
  input logic [IDX_W-1:0] idx_i,
  input logic [7:0]       wdata_i
);
  logic [7:0] run_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (busy_i) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  p_busy_len_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(busy_i) |-> ($past(run_q) == 8'(REC_BYTES-1)));

  p_busy_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    busy_i |-> (run_q < 8'(REC_BYTES)));

  p_we_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    !busy_i |-> !we_i);

  p_ptr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(busy_i) |-> (ptr_i == (($past(ptr_i) == PTR_W'(N_ENTRIES-1)) ? '0
                                 : PTR_W'($past(ptr_i) + 1'b1))));

  p_ptr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$rose(busy_i) |-> $stable(ptr_i));

  p_ctype_nib_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (we_i && idx_i == IDX_W'(REC_BYTES-2)) |-> (wdata_i[3:0] == 4'h0));

  p_sub_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (we_i && idx_i == IDX_W'(REC_BYTES-1)) |-> (wdata_i == 8'h00));
endmodule

bind ilog_writer ilog_writer_chk #(
  .N_ENTRIES(N_ENTRIES),
  .REC_BYTES(REC_BYTES)
) u_chk (
  .clk_i  (clk_i),
  .rst_n  (rst_n),
  .busy_i (busy_o),
  .ptr_i  (ptr_q),
  .we_i   (mem_we),
  .idx_i  (cnt_q),
  .wdata_i(mem_wdata)
);

// File: tb/ilog_writer_bench.sv
module ilog_writer_bench;
  localparam int N     = 16;
  localparam int REC   = 26;
  localparam int DEPTH = 1 + N * REC;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         present;
  logic         compat;
  logic [127:0] uuid;
  logic [7:0]   slot;
  logic [55:0]  stamp;
  logic [7:0]   ctype;
  logic         busy;
  logic [8:0]   rd_addr;
  logic [7:0]   rd_data;

  always #4 clk = ~clk;

  ilog_writer u_ilog_writer (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .present_i(present),
    .compat_i (compat),
    .uuid_i   (uuid),
    .slot_i   (slot),
    .stamp_i  (stamp),
    .ctype_i  (ctype),
    .busy_o   (busy),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );

  typedef struct {
    int         addr;
    logic [7:0] data;
    string      req;
  } exp_t;

  exp_t       sb_q[$];
  int         tests;
  int         fails;
  int         exp_ptr;
  logic [7:0] model [DEPTH];
  bit         filled [DEPTH];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a[8:0];
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  // monitor: pop expected bytes and compare against the read port
  task automatic drain();
    exp_t       e;
    logic [7:0] d;
    while (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      rd(e.addr, d);
      check(e.req, {24'h0, d}, {24'h0, e.data}, $sformatf("byte at %0d", e.addr));
    end
  endtask

  task automatic push(input int a, input logic [7:0] v, input string req);
    exp_t e;
    model[a]  = v;
    filled[a] = 1'b1;
    e.addr = a; e.data = v; e.req = req;
    sb_q.push_back(e);
  endtask

  // driver: one insertion, expected record pushed to the scoreboard
  task automatic insert(input logic [127:0] u, input logic [7:0] s, input logic [55:0] st,
                        input logic [7:0] ct, input bit disturb);
    int         n;
    int         base;
    logic [7:0] d;
    string      tag;
    @(negedge clk);
    uuid = u; slot = s; stamp = st; ctype = ct; compat = 1'b1; present = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R2", {31'h0, busy}, 32'h0, "busy before third edge");
    @(posedge clk);
    @(negedge clk);
    check("R2", {31'h0, busy}, 32'h1, "busy after third edge");
    exp_ptr = (exp_ptr + 1) % N;
    base    = 1 + exp_ptr * REC;
    tag     = disturb ? "R7" : "R4";
    for (int i = 0; i < 16; i++) push(base + i, u[8*i +: 8], tag);
    push(base + 16, s, tag);
    for (int j = 0; j < 7; j++) push(base + 17 + j, st[8*j +: 8], tag);
    push(base + 24, ct & 8'hF0, "R4");
    push(base + 25, 8'h00, "R4");
    n = 0;
    while (busy === 1'b1 && n < 40) begin
      n++;
      if (disturb && n == 2) begin
        uuid = ~u; slot = ~s; stamp = ~st; ctype = ~ct; present = 1'b0;
      end
      if (disturb && n == 8) present = 1'b1;   // R6: retrigger while busy
      @(negedge clk);
    end
    check(disturb ? "R6" : "R5", n, REC, "busy length in cycles");
    present = 1'b0;
    repeat (5) @(negedge clk);
    check("R2", {31'h0, busy}, 32'h0, "no start on falling presence");
    rd(0, d);
    check(disturb ? "R6" : "R3", {24'h0, d}, exp_ptr, "newest-entry index");
    drain();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R5 watchdog: actual no completion expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    bit         seen;
    tests = 0; fails = 0; exp_ptr = N - 1;
    rst_n = 1'b0; present = 1'b0; compat = 1'b0;
    uuid = '0; slot = '0; stamp = '0; ctype = '0; rd_addr = '0;
    for (int a = 0; a < DEPTH; a++) filled[a] = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R1", {31'h0, busy}, 32'h0, "busy after reset");
    rd(0, d);
    check("R1", {24'h0, d}, 32'h0F, "index after reset");
    rd(DEPTH, d);
    check("R8", {24'h0, d}, 32'h0, "first address past log");
    rd(511, d);
    check("R8", {24'h0, d}, 32'h0, "top address");

    // R2: presence rise with compat low
    @(negedge clk);
    compat = 1'b0; present = 1'b1;
    seen = 1'b0;
    repeat (8) begin
      @(negedge clk);
      if (busy) seen = 1'b1;
    end
    check("R2", {31'h0, seen}, 32'h0, "start without compat");
    present = 1'b0;
    repeat (4) @(negedge clk);
    rd(0, d);
    check("R2", {24'h0, d}, 32'h0F, "index unchanged without compat");

    for (int k = 0; k < 17; k++) begin
      insert({$urandom(), $urandom(), $urandom(), $urandom()}, 8'(k + 1),
             56'({$urandom(), $urandom()}), 8'($urandom()) | 8'h0F, k == 3);
    end

    // R3: after wrap, every entry still matches the model
    for (int a = 1; a < DEPTH; a++) begin
      if (filled[a]) push(a, model[a], "R3");
    end
    drain();
    rd(0, d);
    check("R3", {24'h0, d}, 32'h0, "index after wrap");

    summary();
    $finish;
  end
endmodule